// File: doc/BRIEF.md
# Serial Shift Output Controller

This block drives up to 32 output pins through an external chain of serial-in, parallel-out shift registers. Software holds a 32-bit output image in a data register. When an update is triggered, the block shifts that image out on a serial data line with a shift clock. It then pulses a store strobe so that the chain moves the new values onto its parallel outputs.

The pins form four groups of eight, and each group has its own enable. Only the enabled groups are sent, so a shorter chain needs a shorter frame. Three sources can trigger an update, selected by a 2-bit field: a self-clearing software bit, a count of pulses from a general-purpose timer, or a periodic tick divided from the system clock. The shift-clock rate is programmable, and so is the shift-clock edge on which data changes. A trigger that arrives while a frame is in progress is held and serviced as soon as that frame finishes.

Registers use a simple write strobe with a combinational read. Address 0 holds the output image. Address 1 is control word 0: bit 31 is the update request, bit 30 is busy (read only) and bit 26 is the edge select. Address 2 is control word 1: bits 3:0 are the group enables, bits 21:20 the shift-rate code, bits 24:23 the periodic divider code, bits 26:25 the timer divider code and bits 31:30 the update source.

Top module: `shift_out_ctrl`

## Requirements
- R1: After reset all three registers read 0, and sout_clk, sout_data and sout_store are low.
- R2: The image register (address 0) and control word 1 (address 2) read back exactly the value last written.
- R3: With source 0 (software), writing 1 to bit 31 of address 1 starts exactly one frame. Bit 31 always reads 0.
- R4: A frame sends the pins of the enabled groups (group g holds pins 8g+7..8g) from the highest pin to the lowest. Disabled groups are skipped, so the frame carries 8 bits per enabled group.
- R5: With no group enabled, a trigger produces a store strobe and no shift-clock pulse.
- R6: With the edge bit at 0, the clock idles low, data changes on its rising edge and stays stable across its falling edge. With the edge bit at 1, the clock idles high and the roles of the two edges swap.
- R7: Each shift-clock phase lasts SCK_HALF_BASE << code system cycles: 2, 4, 8 or 16 cycles by default for codes 0 to 3.
- R8: A one-cycle store strobe follows the last bit of every frame.
- R9: Bit 30 of address 1 reads 1 from the start of a frame until its store strobe has been issued, and 0 otherwise.
- R10: Triggers that arrive during a frame merge into one pending update. That update starts on the cycle after the store strobe, so back-to-back store strobes lie 2·H·N+2 cycles apart (H is the phase length, N the number of bits).
- R11: With source 2, an update fires every PER_UNIT × {20,10,5,4} system cycles for divider codes 0 to 3.
- R12: With source 1, an update fires on every {20,10,5,4}-th timer_tick pulse for divider codes 0 to 3.
- R13: The software request bit has no effect when the source is 1, 2 or 3, and source 3 produces no update at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| timer_tick | input | 1 | One-cycle pulse from a general-purpose timer |
| sout_clk | output | 1 | Shift clock to the register chain |
| sout_data | output | 1 | Serial data to the register chain |
| sout_store | output | 1 | Store strobe to the register chain |

## Verification
Two functions can land on the same cycle: a new trigger can arrive while the store strobe of the current frame is still being issued, and the pending update can be launched in the cycle right after that strobe. The bench provokes this with the periodic source set to a 64-cycle period while a full 32-bit frame runs, which takes far longer than one period. Ticks then keep landing on a busy shifter. The bench judges the result by the spacing of consecutive store strobes, which must equal exactly one frame plus two cycles, with no frame lost or doubled.

// File: rtl/shift_out_pkg.sv
package shift_out_pkg;

    localparam int NUM_GRP    = 4;
    localparam int GRP_PINS   = 8;
    localparam int PIN_W      = NUM_GRP * GRP_PINS;
    localparam int GRP_IDX_W  = $clog2(NUM_GRP);
    localparam int BIT_IDX_W  = $clog2(GRP_PINS);

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTL0 = 2'd1;
    localparam logic [1:0] ADDR_CTL1 = 2'd2;

    localparam logic [1:0] SRC_SW  = 2'd0;
    localparam logic [1:0] SRC_TMR = 2'd1;
    localparam logic [1:0] SRC_PER = 2'd2;

    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_STORE} sh_state_e;

    typedef struct packed {
        logic                 found;
        logic [GRP_IDX_W-1:0] grp;
    } grp_pick_t;

    // Division ratio shared by the timer and periodic sources.
    function automatic logic [4:0] rate_mult(input logic [1:0] code);
        case (code)
            2'd0:    rate_mult = 5'd20;
            2'd1:    rate_mult = 5'd10;
            2'd2:    rate_mult = 5'd5;
            default: rate_mult = 5'd4;
        endcase
    endfunction

    // Highest enabled group strictly below the limit.
    function automatic grp_pick_t pick_below(input logic [NUM_GRP-1:0] en,
                                             input logic [GRP_IDX_W:0] lim);
        grp_pick_t r;
        r = '0;
        for (int i = 0; i < NUM_GRP; i++) begin
            if (en[i] && ((GRP_IDX_W+1)'(i) < lim)) begin
                r.found = 1'b1;
                r.grp   = GRP_IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sout_regs.sv
module sout_regs
    import shift_out_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic               busy_i,
    output logic [PIN_W-1:0]   image_o,
    output logic               edge_o,
    output logic [1:0]         src_o,
    output logic [1:0]         sck_code_o,
    output logic [1:0]         per_div_o,
    output logic [1:0]         tmr_div_o,
    output logic [NUM_GRP-1:0] grp_en_o,
    output logic               sw_req_o
);

    typedef struct packed {
        logic [PIN_W-1:0]   image;
        logic               edge_sel;
        logic [1:0]         src;
        logic [1:0]         sck_code;
        logic [1:0]         per_div;
        logic [1:0]         tmr_div;
        logic [NUM_GRP-1:0] grp_en;
        logic               sw_req;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        d.sw_req = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_DATA: d.image = wdata[PIN_W-1:0];
                ADDR_CTL0: begin
                    d.edge_sel = wdata[26];
                    d.sw_req   = wdata[31];
                end
                ADDR_CTL1: begin
                    d.grp_en   = wdata[NUM_GRP-1:0];
                    d.sck_code = wdata[21:20];
                    d.per_div  = wdata[24:23];
                    d.tmr_div  = wdata[26:25];
                    d.src      = wdata[31:30];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_DATA: rdata[PIN_W-1:0] = q.image;
            ADDR_CTL0: begin
                rdata[30] = busy_i;
                rdata[26] = q.edge_sel;
            end
            ADDR_CTL1: begin
                rdata[NUM_GRP-1:0] = q.grp_en;
                rdata[21:20]       = q.sck_code;
                rdata[24:23]       = q.per_div;
                rdata[26:25]       = q.tmr_div;
                rdata[31:30]       = q.src;
            end
            default: ;
        endcase
    end

    assign image_o    = q.image;
    assign edge_o     = q.edge_sel;
    assign src_o      = q.src;
    assign sck_code_o = q.sck_code;
    assign per_div_o  = q.per_div;
    assign tmr_div_o  = q.tmr_div;
    assign grp_en_o   = q.grp_en;
    assign sw_req_o   = q.sw_req;

    // The image only changes through a write to its address.
    p_image_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_DATA) |=> $stable(image_o));

endmodule

// File: rtl/sout_trigger.sv
module sout_trigger
    import shift_out_pkg::*;
#(
    parameter int PER_UNIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_i,
    input  logic [1:0] per_div_i,
    input  logic [1:0] tmr_div_i,
    input  logic       sw_req_i,
    input  logic       timer_tick,
    input  logic       busy_i,
    output logic       start_o
);

    localparam int PCW = $clog2(PER_UNIT * 20 + 1);

    typedef struct packed {
        logic [PCW-1:0] per_cnt;
        logic [4:0]     tmr_cnt;
        logic           pend;
    } trig_t;

    trig_t q, d;
    logic  per_fire, tmr_fire, req;
    logic [PCW-1:0] per_len;
    logic [4:0]     tmr_len;

    always_comb begin
        d        = q;
        per_fire = 1'b0;
        tmr_fire = 1'b0;
        per_len  = PCW'(PER_UNIT) * PCW'(rate_mult(per_div_i));
        tmr_len  = rate_mult(tmr_div_i);

        if (src_i == SRC_PER) begin
            if (q.per_cnt >= per_len - 1'b1) begin
                d.per_cnt = '0;
                per_fire  = 1'b1;
            end else begin
                d.per_cnt = q.per_cnt + 1'b1;
            end
        end else begin
            d.per_cnt = '0;
        end

        if (src_i != SRC_TMR) begin
            d.tmr_cnt = '0;
        end else if (timer_tick) begin
            if (q.tmr_cnt >= tmr_len - 1'b1) begin
                d.tmr_cnt = '0;
                tmr_fire  = 1'b1;
            end else begin
                d.tmr_cnt = q.tmr_cnt + 1'b1;
            end
        end

        req     = (sw_req_i && src_i == SRC_SW) || per_fire || tmr_fire;
        start_o = (q.pend || req) && !busy_i;
        d.pend  = (q.pend || req) && busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // A held request never outlives an idle cycle.
    p_pend_served_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !busy_i) |=> !q.pend || busy_i);

endmodule

// File: rtl/sout_shifter.sv
module sout_shifter
    import shift_out_pkg::*;
#(
    parameter int HALF_BASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [PIN_W-1:0]   image_i,
    input  logic [NUM_GRP-1:0] grp_en_i,
    input  logic               edge_i,
    input  logic [1:0]         sck_code_i,
    output logic               busy_o,
    output logic               sck_o,
    output logic               sdo_o,
    output logic               store_o
);

    localparam int HMAX = HALF_BASE << 3;
    localparam int HCW  = $clog2(HMAX + 1);

    typedef struct packed {
        sh_state_e            st;
        logic [PIN_W-1:0]     img;
        logic [NUM_GRP-1:0]   en;
        logic                 edge_sel;
        logic [HCW-1:0]       hlen;
        logic [HCW-1:0]       hcnt;
        logic                 half;
        logic [GRP_IDX_W-1:0] grp;
        logic [BIT_IDX_W-1:0] bitn;
        logic                 sck;
        logic                 sdo;
        logic                 store;
    } sh_t;

    sh_t q, d;
    grp_pick_t pick;

    always_comb begin
        d       = q;
        d.store = 1'b0;
        pick    = '0;
        case (q.st)
            SH_IDLE: begin
                d.sck = edge_i;
                if (start_i) begin
                    d.img      = image_i;
                    d.en       = grp_en_i;
                    d.edge_sel = edge_i;
                    d.hlen     = HCW'(HALF_BASE) << sck_code_i;
                    d.hcnt     = '0;
                    d.half     = 1'b0;
                    pick       = pick_below(grp_en_i, (GRP_IDX_W+1)'(NUM_GRP));
                    if (pick.found) begin
                        d.st   = SH_SHIFT;
                        d.grp  = pick.grp;
                        d.bitn = BIT_IDX_W'(GRP_PINS - 1);
                        d.sdo  = image_i[{pick.grp, BIT_IDX_W'(GRP_PINS - 1)}];
                        d.sck  = ~edge_i;
                    end else begin
                        d.st    = SH_STORE;
                        d.store = 1'b1;
                    end
                end
            end
            SH_SHIFT: begin
                if (q.hcnt == q.hlen - 1'b1) begin
                    d.hcnt = '0;
                    if (!q.half) begin
                        d.half = 1'b1;
                        d.sck  = q.edge_sel;
                    end else begin
                        d.half = 1'b0;
                        if (q.bitn != '0) begin
                            d.bitn = q.bitn - 1'b1;
                            d.sdo  = q.img[{q.grp, q.bitn - 1'b1}];
                            d.sck  = ~q.edge_sel;
                        end else begin
                            pick = pick_below(q.en, {1'b0, q.grp});
                            if (pick.found) begin
                                d.grp  = pick.grp;
                                d.bitn = BIT_IDX_W'(GRP_PINS - 1);
                                d.sdo  = q.img[{pick.grp, BIT_IDX_W'(GRP_PINS - 1)}];
                                d.sck  = ~q.edge_sel;
                            end else begin
                                d.st    = SH_STORE;
                                d.store = 1'b1;
                            end
                        end
                    end
                end else begin
                    d.hcnt = q.hcnt + 1'b1;
                end
            end
            default: begin
                d.st  = SH_IDLE;
                d.sck = q.edge_sel;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.st != SH_IDLE);
    assign sck_o   = q.sck;
    assign sdo_o   = q.sdo;
    assign store_o = q.store;

    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> q.st == SH_IDLE);

    p_grp_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SH_SHIFT) |-> q.en[q.grp]);

    p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SH_SHIFT && q.half) |-> $stable(sdo_o));

    p_phase_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SH_SHIFT) |-> q.hcnt < q.hlen);

    p_store_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |=> !store_o);

endmodule

// File: rtl/shift_out_ctrl.sv
module shift_out_ctrl
    import shift_out_pkg::*;
#(
    parameter int SCK_HALF_BASE = 2,
    parameter int PER_UNIT      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        timer_tick,
    output logic        sout_clk,
    output logic        sout_data,
    output logic        sout_store
);

    logic [PIN_W-1:0]   image;
    logic               edge_sel, sw_req, busy, start;
    logic [1:0]         src, sck_code, per_div, tmr_div;
    logic [NUM_GRP-1:0] grp_en;

    sout_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy_i     (busy),
        .image_o    (image),
        .edge_o     (edge_sel),
        .src_o      (src),
        .sck_code_o (sck_code),
        .per_div_o  (per_div),
        .tmr_div_o  (tmr_div),
        .grp_en_o   (grp_en),
        .sw_req_o   (sw_req)
    );

    sout_trigger #(.PER_UNIT(PER_UNIT)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .per_div_i  (per_div),
        .tmr_div_i  (tmr_div),
        .sw_req_i   (sw_req),
        .timer_tick (timer_tick),
        .busy_i     (busy),
        .start_o    (start)
    );

    sout_shifter #(.HALF_BASE(SCK_HALF_BASE)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .image_i    (image),
        .grp_en_i   (grp_en),
        .edge_i     (edge_sel),
        .sck_code_i (sck_code),
        .busy_o     (busy),
        .sck_o      (sout_clk),
        .sdo_o      (sout_data),
        .store_o    (sout_store)
    );

    p_store_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sout_store |-> busy);

endmodule

// File: tb/shift_out_ctrl_test.sv
`timescale 1ns/1ps
module shift_out_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        timer_tick = 1'b0;
    logic        sout_clk, sout_data, sout_store;

    shift_out_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_tick(timer_tick),
        .sout_clk(sout_clk), .sout_data(sout_data), .sout_store(sout_store)
    );

    always #4 clk = ~clk;

    int     tests = 0, fails = 0;
    bit     edge_mode = 1'b0, cap_en = 1'b0;
    bit     cap_bits [64];
    int     cap_n = 0, hi_cnt = 0, store_cnt = 0;
    longint cyc = 0, last_t = 0, prev_t = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (sout_store === 1'b1) begin
            store_cnt++;
            prev_t = last_t;
            last_t = cyc;
        end
        if (cap_en && sout_clk != edge_mode) hi_cnt++;
    end

    always @(sout_clk) begin
        if (cap_en && sout_clk == edge_mode && cap_n < 64) begin
            cap_bits[cap_n] = sout_data;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctl1(input int src, input int tmr,
                                            input int per, input int sck,
                                            input int en);
        logic [31:0] v = '0;
        v[31:30] = 2'(src); v[26:25] = 2'(tmr); v[24:23] = 2'(per);
        v[21:20] = 2'(sck); v[3:0] = 4'(en);
        return v;
    endfunction

    task automatic clr_cap();
        cap_n = 0; hi_cnt = 0; store_cnt = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_store(input int n, input int maxc);
        for (int i = 0; i < maxc && store_cnt < n; i++) @(negedge clk);
    endtask

    task automatic check_frame(input logic [31:0] img, input logic [3:0] en,
                               input string req);
        int n = 0, bad = 0;
        for (int p = 31; p >= 0; p--) begin
            if (en[p/8]) begin
                if (n < cap_n && cap_bits[n] != img[p]) bad++;
                n++;
            end
        end
        chk(cap_n == n, req, "frame bit count", cap_n, n);
        chk(bad == 0, req, "bits out of order or wrong", bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end
        chk(sout_clk == 0 && sout_data == 0 && sout_store == 0, "R1",
            "outputs after reset", {sout_clk, sout_data, sout_store}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd0, 32'hA5C3_0F96);
        rd(2'd0, v);
        chk(v == 32'hA5C3_0F96, "R2", "image readback", v, 32'hA5C3_0F96);
        wr(2'd2, mk_ctl1(3, 1, 3, 2, 4'hA));
        rd(2'd2, v);
        chk(v == mk_ctl1(3, 1, 3, 2, 4'hA), "R2", "control readback", v,
            mk_ctl1(3, 1, 3, 2, 4'hA));
        wr(2'd2, 32'h0);
    endtask

    task automatic t_sw_frame();
        logic [31:0] v;
        wr(2'd2, mk_ctl1(0, 0, 0, 0, 4'hF));
        wr(2'd1, 32'h0);
        edge_mode = 1'b0;
        wr(2'd0, 32'h8421_F00D);
        clr_cap(); cap_en = 1'b1;
        wr(2'd1, 32'h8000_0000);
        idle(3);
        rd(2'd1, v);
        chk(v[30] == 1'b1, "R9", "busy during frame", v[30], 1);
        chk(v[31] == 1'b0, "R3", "request bit self-clears", v[31], 0);
        wait_store(1, 2000);
        idle(200);
        cap_en = 1'b0;
        chk(store_cnt == 1, "R3", "one frame per request", store_cnt, 1);
        chk(store_cnt == 1, "R8", "single store strobe", store_cnt, 1);
        check_frame(32'h8421_F00D, 4'hF, "R4");
        chk(hi_cnt == 32 * 2, "R7", "code 0 phase cycles", hi_cnt, 64);
        rd(2'd1, v);
        chk(v[30] == 1'b0, "R9", "busy after store", v[30], 0);
    endtask

    task automatic t_partial();
        wr(2'd2, mk_ctl1(0, 0, 0, 2, 4'h5));
        wr(2'd1, 32'h0400_0000);
        edge_mode = 1'b1;
        idle(3);
        chk(sout_clk == 1'b1, "R6", "idle level with edge 1", sout_clk, 1);
        wr(2'd0, 32'h3C5A_9617);
        clr_cap(); cap_en = 1'b1;
        wr(2'd1, 32'h8400_0000);
        wait_store(1, 3000);
        idle(20);
        cap_en = 1'b0;
        check_frame(32'h3C5A_9617, 4'h5, "R4");
        chk(hi_cnt == 16 * 8, "R7", "code 2 phase cycles", hi_cnt, 128);
        chk(store_cnt == 1, "R6", "edge 1 frame completes", store_cnt, 1);
        wr(2'd1, 32'h0);
        edge_mode = 1'b0;
        idle(3);
        chk(sout_clk == 1'b0, "R6", "idle level with edge 0", sout_clk, 0);
    endtask

    task automatic t_no_groups();
        wr(2'd2, mk_ctl1(0, 0, 0, 0, 0));
        idle(2);
        clr_cap(); cap_en = 1'b1;
        wr(2'd1, 32'h8000_0000);
        idle(50);
        cap_en = 1'b0;
        chk(store_cnt == 1, "R5", "store without groups", store_cnt, 1);
        chk(cap_n == 0, "R5", "no shift pulses", cap_n, 0);
    endtask

    task automatic t_pending();
        wr(2'd2, mk_ctl1(0, 0, 0, 0, 4'hF));
        wr(2'd0, 32'h0F0F_3355);
        clr_cap(); cap_en = 1'b1;
        wr(2'd1, 32'h8000_0000);
        idle(10);
        wr(2'd1, 32'h8000_0000);
        idle(10);
        wr(2'd1, 32'h8000_0000);
        idle(600);
        cap_en = 1'b0;
        chk(store_cnt == 2, "R10", "merged pending requests", store_cnt, 2);
        chk(cap_n == 64, "R10", "two full frames", cap_n, 64);
    endtask

    task automatic t_ignore();
        wr(2'd2, mk_ctl1(1, 0, 0, 0, 4'hF));
        clr_cap();
        wr(2'd1, 32'h8000_0000);
        idle(300);
        chk(store_cnt == 0, "R13", "request ignored in timer mode", store_cnt, 0);
        wr(2'd2, mk_ctl1(3, 0, 3, 0, 4'hF));
        wr(2'd1, 32'h8000_0000);
        idle(300);
        chk(store_cnt == 0, "R13", "no update with source 3", store_cnt, 0);
    endtask

    task automatic tick();
        @(negedge clk); timer_tick = 1'b1;
        @(negedge clk); timer_tick = 1'b0;
        idle(2);
    endtask

    task automatic t_timer();
        wr(2'd2, mk_ctl1(1, 3, 0, 0, 4'h1));
        wr(2'd0, 32'h0000_00B4);
        clr_cap(); cap_en = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        idle(100);
        chk(store_cnt == 0, "R12", "no update after 3 ticks", store_cnt, 0);
        tick();
        idle(100);
        cap_en = 1'b0;
        chk(store_cnt == 1, "R12", "update on 4th tick", store_cnt, 1);
        check_frame(32'h0000_00B4, 4'h1, "R12");
    endtask

    task automatic t_periodic();
        wr(2'd2, mk_ctl1(2, 0, 1, 0, 4'h1));
        clr_cap();
        wait_store(3, 1000);
        chk(last_t - prev_t == 160, "R11", "periodic interval code 1",
            last_t - prev_t, 160);
        wr(2'd2, mk_ctl1(0, 0, 0, 0, 4'hF));
        idle(300);
    endtask

    task automatic t_back_to_back();
        wr(2'd2, mk_ctl1(2, 0, 3, 0, 4'hF));
        clr_cap();
        wait_store(3, 2000);
        chk(store_cnt >= 3, "R10", "frames under overrun", store_cnt, 3);
        chk(last_t - prev_t == 130, "R10", "back-to-back store spacing",
            last_t - prev_t, 130);
        wr(2'd2, mk_ctl1(0, 0, 0, 0, 4'hF));
        idle(400);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regs();
        t_sw_frame();
        t_partial();
        t_no_groups();
        t_pending();
        t_ignore();
        t_timer();
        t_periodic();
        t_back_to_back();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule